// File: doc/BRIEF.md
# Sliding-Window Complex Autocorrelator

This block takes a stream of complex samples, each a signed in-phase and quadrature pair qualified by a valid strobe. It produces a running lag-K autocorrelation over the most recent N samples. Each accepted sample x[n] is paired with the sample that arrived K accepted samples earlier. The block forms the conjugate product p[n] = x[n-K]·conj(x[n]) and keeps the sum of the last N such products. It does not add up the whole window again on every sample. Instead it updates the sum recursively: it adds the newest product and subtracts the product that has just left the window.

The design uses one multiplier. Each product is stored once in an N-deep history buffer, and the buffer's oldest entry supplies the term to subtract. The three-operand update (old sum, plus newest, minus oldest) runs on the real and imaginary rails separately. The accumulator carries log2(N) guard bits above the product width, so the exact sum never overflows. A parameter selects whether the result is scaled by 1/N through an arithmetic right shift or is output unscaled. The lag K only sets the length of the sample delay line ahead of the multiplier.

Top module: `sliding_acorr`

## Requirements
- R1: For each accepted sample x[n] = a_n + j·b_n, the block forms the term p[n] = x[n-K]·conj(x[n]). Its real part is a_{n-K}·a_n + b_{n-K}·b_n and its imaginary part is b_{n-K}·a_n − a_{n-K}·b_n. Samples that would precede the first accepted sample since reset or clear count as zero.
- R2: After accepted sample n, the unscaled result equals the sum of p[m] over the last N accepted samples. Fewer terms are summed while fewer than N samples have been accepted since reset or clear.
- R3: With SCALE = SCALE_SHIFT (encoding 1), each output rail is the unscaled sum arithmetically shifted right by log2(N), rounding toward minus infinity, and is 2W+1 bits wide. With SCALE = SCALE_NONE (encoding 0), each rail is the unscaled sum itself, 2W+1+log2(N) bits wide.
- R4: Full-scale inputs, including the most negative W-bit value on both rails, give the exact sum with no wrap-around.
- R5: out_valid is high exactly two clock cycles after a cycle where in_valid is high and clr is low, provided clr stays low in the following cycle. It is low in every other cycle.
- R6: A cycle with in_valid low changes neither the sample history nor the product history, and out_i and out_q keep their values.
- R7: A cycle with clr high takes priority over in_valid. It empties both histories, sets the outputs to zero and drops out_valid on the next clock edge.
- R8: While rst_n is low, the outputs are zero and out_valid is low at once. After release, the block behaves as after a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all state |
| in_valid | input | 1 | Qualifies in_i and in_q |
| in_i | input | W | Sample real part, signed |
| in_q | input | W | Sample imaginary part, signed |
| out_valid | output | 1 | New correlation value this cycle |
| out_i | output | OUT_W | Correlation real part, signed |
| out_q | output | OUT_W | Correlation imaginary part, signed |

## Verification
The bench drives one stimulus stream into two instances, both with W = 17 so that the most negative sample value can reach the multiplier. The first instance uses N = 8, K = 3 and the shift scaling. Its short window fills and wraps many times, and the three-stage lag checks how zero history is handled. The second instance uses N = 4, K = 1 with no scaling, so the raw guard-bit sum is visible on its output. Low-amplitude random samples make negative sums that are not multiples of N, which tests the floor rounding of the shift.

// File: rtl/acorr_pkg.sv
package acorr_pkg;

  // Output scaling choice: raw window sum or sum divided by N via shift.
  typedef enum logic {
    SCALE_NONE  = 1'b0,
    SCALE_SHIFT = 1'b1
  } scale_e;

  // Full-precision width of a conjugate product of two W-bit samples.
  function automatic int prod_width(input int w);
    return 2 * w + 1;
  endfunction

endpackage

// File: rtl/acorr_lag_line.sv
// K-stage complex sample delay; advances only on accepted samples.
module acorr_lag_line #(
  parameter int W = 17,
  parameter int K = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] din_i,
  input  logic signed [W-1:0] din_q,
  output logic signed [W-1:0] dout_i,
  output logic signed [W-1:0] dout_q
);

  for (genvar g = 0; g < K; g++) begin : g_stage
    logic signed [W-1:0] src_i, src_q;
    logic signed [W-1:0] q_i, q_q;
    logic signed [W-1:0] nx_i, nx_q;

    if (g == 0) begin : g_head
      assign src_i = din_i;
      assign src_q = din_q;
    end else begin : g_tail
      assign src_i = g_stage[g-1].q_i;
      assign src_q = g_stage[g-1].q_q;
    end

    always_comb begin
      nx_i = q_i;
      nx_q = q_q;
      if (clr) begin
        nx_i = '0;
        nx_q = '0;
      end else if (en) begin
        nx_i = src_i;
        nx_q = src_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_i <= '0;
        q_q <= '0;
      end else begin
        q_i <= nx_i;
        q_q <= nx_q;
      end
    end
  end

  assign dout_i = g_stage[K-1].q_i;
  assign dout_q = g_stage[K-1].q_q;

endmodule

// File: rtl/acorr_conj_mult.sv
// Registered conjugate product: p = lagged * conj(current).
module acorr_conj_mult #(
  parameter int W  = 17,
  parameter int PW = 2 * W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [W-1:0]  lag_i,
  input  logic signed [W-1:0]  lag_q,
  input  logic signed [W-1:0]  cur_i,
  input  logic signed [W-1:0]  cur_q,
  output logic                 p_valid,
  output logic signed [PW-1:0] p_re,
  output logic signed [PW-1:0] p_im
);

  logic signed [PW-1:0] ac, bd, bc, ad;
  logic signed [PW-1:0] re_nx, im_nx;
  logic                 vld_nx;

  always_comb begin
    ac = PW'(lag_i) * PW'(cur_i);
    bd = PW'(lag_q) * PW'(cur_q);
    bc = PW'(lag_q) * PW'(cur_i);
    ad = PW'(lag_i) * PW'(cur_q);
    vld_nx = en & ~clr;
    re_nx  = p_re;
    im_nx  = p_im;
    if (clr) begin
      re_nx = '0;
      im_nx = '0;
    end else if (en) begin
      re_nx = ac + bd;
      im_nx = bc - ad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid <= 1'b0;
      p_re    <= '0;
      p_im    <= '0;
    end else begin
      p_valid <= vld_nx;
      p_re    <= re_nx;
      p_im    <= im_nx;
    end
  end

endmodule

// File: rtl/acorr_prod_hist.sv
// N-entry circular history of products; the entry being overwritten is
// the one leaving the window. Reads as zero until the ring has filled.
module acorr_prod_hist #(
  parameter int PW = 35,
  parameter int N  = 64,
  localparam int AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 push,
  input  logic signed [PW-1:0] new_re,
  input  logic signed [PW-1:0] new_im,
  output logic signed [PW-1:0] old_re,
  output logic signed [PW-1:0] old_im
);

  logic signed [PW-1:0] mem_re [N];
  logic signed [PW-1:0] mem_im [N];
  logic [AW-1:0]        ptr, ptr_nx;
  logic                 full, full_nx;
  logic                 wr_en;

  assign wr_en  = push & ~clr;
  assign old_re = full ? mem_re[ptr] : '0;
  assign old_im = full ? mem_im[ptr] : '0;

  always_comb begin
    ptr_nx  = ptr;
    full_nx = full;
    if (clr) begin
      ptr_nx  = '0;
      full_nx = 1'b0;
    end else if (push) begin
      if (ptr == AW'(N - 1)) begin
        ptr_nx  = '0;
        full_nx = 1'b1;
      end else begin
        ptr_nx = ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      full <= 1'b0;
    end else begin
      ptr  <= ptr_nx;
      full <= full_nx;
    end
  end

  // Storage array: no reset, contents are masked by 'full' until written.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_re[ptr] <= new_re;
      mem_im[ptr] <= new_im;
    end
  end

  // R2: once the window has filled it stays filled until a clear.
  a_r2_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> full);

endmodule

// File: rtl/acorr_accum.sv
// Three-operand recursive window sum per rail, plus output scaling.
module acorr_accum
  import acorr_pkg::*;
#(
  parameter int     PW    = 35,
  parameter int     N     = 64,
  parameter scale_e SCALE = SCALE_SHIFT,
  localparam int    SH    = $clog2(N),
  localparam int    ACC_W = PW + SH,
  localparam int    OUT_W = (SCALE == SCALE_SHIFT) ? PW : ACC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [PW-1:0]    add_re,
  input  logic signed [PW-1:0]    add_im,
  input  logic signed [PW-1:0]    sub_re,
  input  logic signed [PW-1:0]    sub_im,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);

  localparam logic signed [ACC_W-1:0] LIM = {1'b0, 1'b1, {(ACC_W-2){1'b0}}};

  logic signed [ACC_W-1:0] acc_re, acc_im, acc_re_nx, acc_im_nx;
  logic                    vld_nx;

  always_comb begin
    vld_nx    = en & ~clr;
    acc_re_nx = acc_re;
    acc_im_nx = acc_im;
    if (clr) begin
      acc_re_nx = '0;
      acc_im_nx = '0;
    end else if (en) begin
      acc_re_nx = acc_re + ACC_W'(add_re) - ACC_W'(sub_re);
      acc_im_nx = acc_im + ACC_W'(add_im) - ACC_W'(sub_im);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re    <= '0;
      acc_im    <= '0;
      out_valid <= 1'b0;
    end else begin
      acc_re    <= acc_re_nx;
      acc_im    <= acc_im_nx;
      out_valid <= vld_nx;
    end
  end

  if (SCALE == SCALE_SHIFT) begin : g_shift
    assign out_re = OUT_W'(acc_re >>> SH);
    assign out_im = OUT_W'(acc_im >>> SH);
  end else begin : g_raw
    assign out_re = acc_re;
    assign out_im = acc_im;
  end

  // R6: without a new product the running sum is left untouched.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(acc_re) && $stable(acc_im)));

  // R7: a clear empties the sum and drops the strobe on the next edge.
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_re == '0 && acc_im == '0 && !out_valid));

  // R4: the window sum stays inside the range of N full-scale products.
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_re <= LIM && acc_re >= -LIM && acc_im <= LIM && acc_im >= -LIM));

endmodule

// File: rtl/sliding_acorr.sv
module sliding_acorr
  import acorr_pkg::*;
#(
  parameter int     W     = 17,
  parameter int     N     = 64,
  parameter int     K     = 1,
  parameter scale_e SCALE = SCALE_SHIFT,
  localparam int    PW    = prod_width(W),
  localparam int    ACC_W = PW + $clog2(N),
  localparam int    OUT_W = (SCALE == SCALE_SHIFT) ? PW : ACC_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    in_valid,
  input  logic signed [W-1:0]     in_i,
  input  logic signed [W-1:0]     in_q,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);

  logic signed [W-1:0]  lag_i, lag_q;
  logic                 prod_valid;
  logic signed [PW-1:0] prod_re, prod_im;
  logic signed [PW-1:0] old_re, old_im;

  acorr_lag_line #(.W(W), .K(K)) u_lag (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .en     (in_valid),
    .din_i  (in_i),
    .din_q  (in_q),
    .dout_i (lag_i),
    .dout_q (lag_q)
  );

  acorr_conj_mult #(.W(W), .PW(PW)) u_mult (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .en      (in_valid),
    .lag_i   (lag_i),
    .lag_q   (lag_q),
    .cur_i   (in_i),
    .cur_q   (in_q),
    .p_valid (prod_valid),
    .p_re    (prod_re),
    .p_im    (prod_im)
  );

  acorr_prod_hist #(.PW(PW), .N(N)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .push   (prod_valid),
    .new_re (prod_re),
    .new_im (prod_im),
    .old_re (old_re),
    .old_im (old_im)
  );

  acorr_accum #(.PW(PW), .N(N), .SCALE(SCALE)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .en        (prod_valid),
    .add_re    (prod_re),
    .add_im    (prod_im),
    .sub_re    (old_re),
    .sub_im    (old_im),
    .out_valid (out_valid),
    .out_re    (out_i),
    .out_im    (out_q)
  );

  // R5: an accepted sample yields a strobe two edges later.
  a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) ##1 !clr |=> out_valid);

  // R5: no strobe without a sample two cycles earlier.
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(prod_valid));

endmodule

// File: tb/sliding_acorr_test.sv
`timescale 1ns/1ps
module sliding_acorr_test;
  import acorr_pkg::*;

  localparam int W  = 17;
  localparam int NA = 8;
  localparam int KA = 3;
  localparam int NB = 4;
  localparam int KB = 1;
  localparam int SHA = $clog2(NA);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                rst_n, clr, in_valid;
  logic signed [W-1:0] in_i, in_q;
  logic                a_valid, b_valid;
  logic signed [2*W:0]   a_i, a_q;
  logic signed [2*W+2:0] b_i, b_q;

  sliding_acorr #(.W(W), .N(NA), .K(KA), .SCALE(SCALE_SHIFT)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .out_valid(a_valid), .out_i(a_i), .out_q(a_q));

  sliding_acorr #(.W(W), .N(NB), .K(KB), .SCALE(SCALE_NONE)) uut_raw (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .out_valid(b_valid), .out_i(b_i), .out_q(b_q));

  int    total = 0;
  int    bad = 0;
  bit    finished = 0;
  string req = "R8";

  int xi[$];
  int xq[$];
  longint e1[4], e2[4], cur[4];
  bit v1, v2;

  // Direct window sum of conjugate products over the accepted history.
  function automatic longint wsum(bit im, int n, int k);
    longint s = 0;
    int len = xi.size();
    int lo = (len > n) ? len - n : 0;
    for (int m = lo; m < len; m++) begin
      longint a, b, c, d;
      a = (m >= k) ? longint'(xi[m-k]) : 0;
      b = (m >= k) ? longint'(xq[m-k]) : 0;
      c = xi[m];
      d = xq[m];
      s += im ? (b * c - a * d) : (a * c + b * d);
    end
    return s;
  endfunction

  task automatic chk(string what, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs();
    chk("R5 strobe scaled", longint'(a_valid), longint'(v2));
    chk("re scaled",        longint'(a_i), e2[0]);
    chk("im scaled",        longint'(a_q), e2[1]);
    chk("R5 strobe raw",    longint'(b_valid), longint'(v2));
    chk("re raw",           longint'(b_i), e2[2]);
    chk("im raw",           longint'(b_q), e2[3]);
  endtask

  task automatic tick(bit v, int i, int q, bit c = 0, bit r = 0);
    check_outs();
    in_valid = v;
    in_i = W'(i);
    in_q = W'(q);
    clr = c;
    if (r) rst_n = 1'b0;
    if (c || r) begin
      xi.delete();
      xq.delete();
    end else if (v) begin
      xi.push_back(i);
      xq.push_back(q);
    end
    cur[0] = wsum(0, NA, KA) >>> SHA;
    cur[1] = wsum(1, NA, KA) >>> SHA;
    cur[2] = wsum(0, NB, KB);
    cur[3] = wsum(1, NB, KB);
    e2 = e1;
    v2 = v1;
    e1 = cur;
    v1 = v && !c && !r;
    if (c || r) begin
      e2 = cur;
      v2 = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    if (r) rst_n = 1'b1;
  endtask

  function automatic int rnd(int lo, int hi);
    return int'($urandom_range(32'(hi - lo))) + lo;
  endfunction

  initial begin
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    foreach (e1[j]) begin e1[j] = 0; e2[j] = 0; end
    v1 = 0; v2 = 0;
    repeat (2) @(negedge clk);
    req = "R8";  // reset state at the ports
    check_outs();
    rst_n = 1'b1;

    req = "R1";  // hand-picked samples through the lag and multiplier
    tick(1, 3, 4);   tick(1, 1, -2);  tick(1, -5, 7);
    tick(1, 2, 2);   tick(1, 0, -1);  tick(1, 6, 0);

    req = "R2";  // continuous full-range stream, window wraps
    for (int n = 0; n < 40; n++) tick(1, rnd(-65536, 65535), rnd(-65536, 65535));

    req = "R6";  // gaps: invalid cycles carry junk data
    for (int n = 0; n < 60; n++)
      tick(bit'($urandom_range(1)), rnd(-65536, 65535), rnd(-65536, 65535));

    req = "R4";  // full-scale corners
    for (int n = 0; n < 20; n++) tick(1, -65536, -65536);
    for (int n = 0; n < 20; n++)
      if (n % 2 == 0) tick(1, -65536, 65535); else tick(1, 65535, -65536);
    for (int n = 0; n < 12; n++) tick(1, 65535, 65535);

    req = "R7";  // clear wins over valid, then back-to-back clears
    for (int n = 0; n < 10; n++) tick(1, rnd(-65536, 65535), rnd(-65536, 65535));
    tick(1, 1234, -4321, 1);
    for (int n = 0; n < 12; n++) tick(1, rnd(-65536, 65535), rnd(-65536, 65535));
    tick(1, 5, 5, 1);
    tick(0, 0, 0, 1);
    for (int n = 0; n < 5; n++) tick(1, rnd(-100, 100), rnd(-100, 100));

    req = "R3";  // small values: negative sums not divisible by N
    for (int n = 0; n < 40; n++) tick(1, rnd(-3, 3), rnd(-3, 3));

    req = "R5";  // strobe spacing
    tick(1, 7, -3); tick(0, 0, 0); tick(0, 0, 0); tick(1, -2, 9);
    tick(1, 4, 4);  tick(0, 1, 1); tick(1, -8, 2); tick(0, 0, 0);

    req = "R8";  // asynchronous reset mid-stream
    tick(0, 0, 0, 0, 1);
    for (int n = 0; n < 15; n++) tick(1, rnd(-65536, 65535), rnd(-65536, 65535));

    for (int n = 0; n < 4; n++) tick(0, 0, 0);
    check_outs();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired in %s", req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule